// File: doc/BRIEF.md
# Push-Button Power State Controller

This block decides whether a battery- or bus-powered card reader is powered. It watches a momentary push-button that shorts its input to ground, filters contact bounce with a cycle-counted window, and toggles the unit in push-on/push-off fashion. A press while off powers the unit straight away. A press while on does not cut power. Instead it raises an off-request line to the host controller and waits for the host's acknowledge.

The host can also shut the unit down on its own by driving the acknowledge line high. If the host leaves the acknowledge looped back to the request, shutdown follows one cycle after the request rises. While USB bus power is present the unit is held on, and neither the button nor the acknowledge can turn it off. The button input is synchronised to the clock. The acknowledge and bus-present inputs are taken as already synchronous.

Top module: `pwr_button_ctrl`

## Requirements
- R1: During and after synchronous reset the unit is off: `pwr_en` = 0 and `off_req` = 0.
- R2: While off, a button press (`btn_n` = 0) held for at least `DEBOUNCE_CYC` consecutive clock edges turns the unit on (`pwr_en` = 1). With two synchronizer stages, `pwr_en` rises on edge `DEBOUNCE_CYC`+2, counted from the first edge that samples the press. A press of `DEBOUNCE_CYC`-1 edges has no effect.
- R3: While on, a qualified press raises `off_req` to 1, and `pwr_en` stays 1. `off_req` = 1 never occurs while `pwr_en` = 0.
- R4: While on or requesting, without bus power, `host_ack` = 1 at a clock edge turns the unit off on that edge, and `off_req` drops to 0.
- R5: With `host_ack` wired to `off_req`, a qualified press while on makes `off_req` high for exactly one cycle and then leaves the unit off.
- R6: While `vbus_ok` = 1 the unit is on with `off_req` = 0 after the next edge, whatever the button or `host_ack` do. A pending request is cancelled. When `vbus_ok` later drops, the unit stays on.
- R7: After any change of power state, the button must be seen released for a full debounce window before another press is accepted. A single long press therefore toggles only once, and a press that follows a release shorter than the window is ignored.
- R8: A qualified press while `off_req` = 1 is ignored. The request stays pending until `host_ack` or `vbus_ok` arrives.
- R9: Any release during the debounce window restarts the count. Two presses of `DEBOUNCE_CYC`-1 edges separated by a short release do not turn the unit on.
- R10: When inputs coincide on one edge, bus presence wins over the acknowledge, and the acknowledge wins over a completing button press.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_n | input | 1 | Push-button, low while closed (asynchronous) |
| host_ack | input | 1 | Host acknowledge or forced power-off, active high |
| vbus_ok | input | 1 | USB bus power present, active high |
| pwr_en | output | 1 | Power enable for the unit's supplies |
| off_req | output | 1 | Request to the host for permission to shut down |

## Verification
The delicate case is a debounce window that completes on the same edge as the arrival of bus power or of the host acknowledge. The press path and the override path then both compute a next state, and only R10's priority decides the result. The bench counts the press latency exactly, so the override input changes just before the edge on which the press would be accepted. A bus arrival on that edge must leave the unit on with no request raised. An acknowledge on that edge must leave the unit off rather than requesting.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    typedef enum logic [1:0] {
        PS_OFF = 2'b00,
        PS_ON  = 2'b01,
        PS_REQ = 2'b10
    } pwr_state_t;

    typedef struct packed {
        logic bus;
        logic ack;
        logic press;
    } pwr_evt_t;

    // Priority: bus presence, then host acknowledge, then button.
    function automatic pwr_state_t pwr_next(input pwr_state_t cur, input pwr_evt_t ev);
        pwr_state_t nxt;
        nxt = cur;
        if (ev.bus) begin
            nxt = PS_ON;
        end else if (ev.ack && cur != PS_OFF) begin
            nxt = PS_OFF;
        end else if (ev.press) begin
            case (cur)
                PS_OFF:  nxt = PS_ON;
                PS_ON:   nxt = PS_REQ;
                default: nxt = cur;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/pwr_btn_sync.sv
module pwr_btn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_n,
    output logic pressed
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= 1'b1;
                else     chain <= btn_n;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], btn_n};
            end
        end
    endgenerate

    assign pressed = ~chain[STAGES-1];

endmodule

// File: rtl/pwr_debounce.sv
module pwr_debounce #(
    parameter int DEBOUNCE_CYC = 20000
) (
    input  logic clk,
    input  logic rst,
    input  logic pressed,
    input  logic rearm,
    output logic press_evt
);
    localparam int CNT_W = $clog2(DEBOUNCE_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DEBOUNCE_CYC - 1);

    logic             armed;
    logic [CNT_W-1:0] cnt;

    assign press_evt = armed && pressed && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || rearm) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (armed) begin
            if (!pressed) begin
                cnt <= '0;
            end else if (cnt == LAST) begin
                armed <= 1'b0;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            if (pressed) begin
                cnt <= '0;
            end else if (cnt == LAST) begin
                armed <= 1'b1;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R2 / R9: an accepted press was seen held on the previous edge too
    p_evt_held_r2: assert property (@(posedge clk) disable iff (rst)
        press_evt |-> $past(pressed));

    // R7: a press is never accepted on the edge right after a rearm
    p_rearm_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        rearm |=> !press_evt);

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import pwr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic press_evt,
    input  logic host_ack,
    input  logic vbus_ok,
    output logic state_chg,
    output logic pwr_en,
    output logic off_req
);
    pwr_state_t state, nxt;
    pwr_evt_t   ev;

    always_comb begin
        ev.bus   = vbus_ok;
        ev.ack   = host_ack;
        ev.press = press_evt;
        nxt      = pwr_next(state, ev);
        state_chg = (nxt != state);
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PS_OFF;
        else     state <= nxt;
    end

    assign pwr_en  = (state != PS_OFF);
    assign off_req = (state == PS_REQ);

    // R3: a request only exists while powered
    p_req_needs_on_r3: assert property (@(posedge clk) disable iff (rst)
        off_req |-> pwr_en);

    // R6: bus presence forces on with no request
    p_bus_forces_on_r6: assert property (@(posedge clk) disable iff (rst)
        vbus_ok |=> (pwr_en && !off_req));

    // R4: acknowledge without bus power shuts down
    p_ack_shuts_r4: assert property (@(posedge clk) disable iff (rst)
        (!vbus_ok && host_ack && pwr_en) |=> !pwr_en);

    // R8: a pending request holds until ack or bus
    p_req_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (off_req && !host_ack && !vbus_ok) |=> off_req);

endmodule

// File: rtl/pwr_button_ctrl.sv
module pwr_button_ctrl #(
    parameter int DEBOUNCE_CYC = 20000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_n,
    input  logic host_ack,
    input  logic vbus_ok,
    output logic pwr_en,
    output logic off_req
);
    logic pressed;
    logic press_evt;
    logic state_chg;

    pwr_btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .btn_n   (btn_n),
        .pressed (pressed)
    );

    pwr_debounce #(.DEBOUNCE_CYC(DEBOUNCE_CYC)) u_deb (
        .clk       (clk),
        .rst       (rst),
        .pressed   (pressed),
        .rearm     (state_chg),
        .press_evt (press_evt)
    );

    pwr_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .press_evt (press_evt),
        .host_ack  (host_ack),
        .vbus_ok   (vbus_ok),
        .state_chg (state_chg),
        .pwr_en    (pwr_en),
        .off_req   (off_req)
    );

    // R1: reset leaves the unit off
    p_reset_off_r1: assert property (@(posedge clk)
        $past(rst) |-> (!pwr_en && !off_req));

endmodule

// File: tb/pwr_button_ctrl_test.sv
`timescale 1ns/1ps
module pwr_button_ctrl_test;
    localparam int DEB  = 8;
    localparam int IDLE = DEB + 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn_n = 1'b1;
    logic ack_drv = 1'b0;
    logic tie_mode = 1'b0;
    logic vbus_ok = 1'b0;
    logic host_ack;
    logic pwr_en, off_req;
    logic done = 1'b0;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    assign host_ack = tie_mode ? off_req : ack_drv;

    pwr_button_ctrl #(.DEBOUNCE_CYC(DEB), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .btn_n(btn_n), .host_ack(host_ack),
        .vbus_ok(vbus_ok), .pwr_en(pwr_en), .off_req(off_req)
    );

    typedef struct packed {
        logic [1:0] op;     // 0 press, 1 ack pulse, 2 bus level
        logic [7:0] arg;
        logic       en;
        logic       req;
        logic [3:0] tag;    // requirement number for messages
    } step_t;

    localparam int NSTEP = 13;
    localparam step_t STEPS [NSTEP] = '{
        '{2'd0, 8'd5,  1'b0, 1'b0, 4'd2},
        '{2'd0, 8'd8,  1'b1, 1'b0, 4'd2},
        '{2'd0, 8'd8,  1'b1, 1'b1, 4'd3},
        '{2'd0, 8'd8,  1'b1, 1'b1, 4'd8},
        '{2'd1, 8'd0,  1'b0, 1'b0, 4'd4},
        '{2'd0, 8'd30, 1'b1, 1'b0, 4'd7},
        '{2'd2, 8'd1,  1'b1, 1'b0, 4'd6},
        '{2'd0, 8'd8,  1'b1, 1'b0, 4'd6},
        '{2'd1, 8'd0,  1'b1, 1'b0, 4'd6},
        '{2'd2, 8'd0,  1'b1, 1'b0, 4'd6},
        '{2'd1, 8'd0,  1'b0, 1'b0, 4'd4},
        '{2'd2, 8'd1,  1'b1, 1'b0, 4'd6},
        '{2'd2, 8'd0,  1'b1, 1'b0, 4'd6}
    };

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press(input int n);
        @(negedge clk) btn_n = 1'b0;
        repeat (n) @(negedge clk);
        btn_n = 1'b1;
    endtask

    task automatic ack_pulse();
        @(negedge clk) ack_drv = 1'b1;
        @(negedge clk) ack_drv = 1'b0;
    endtask

    task automatic check(input logic en_exp, input logic req_exp, input string what);
        n_run++;
        if (pwr_en !== en_exp || off_req !== req_exp) begin
            n_fail++;
            $display("FAIL %s: pwr_en/off_req = %b/%b, expected %b/%b",
                     what, pwr_en, off_req, en_exp, req_exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        idle(3);
        check(1'b0, 1'b0, "R1 during reset");
        rst = 1'b0;
        idle(1);
        check(1'b0, 1'b0, "R1 after reset");
        idle(IDLE);

        for (int i = 0; i < NSTEP; i++) begin
            case (STEPS[i].op)
                2'd0: press(int'(STEPS[i].arg));
                2'd1: ack_pulse();
                default: vbus_ok = STEPS[i].arg[0];
            endcase
            idle(IDLE);
            check(STEPS[i].en, STEPS[i].req,
                  $sformatf("R%0d table step %0d", STEPS[i].tag, i));
        end

        // Back to off through the acknowledge (R4)
        ack_pulse();
        idle(IDLE);
        check(1'b0, 1'b0, "R4 ack from on");

        // R9: interrupted presses restart the count
        @(negedge clk) btn_n = 1'b0;
        idle(DEB - 1);
        btn_n = 1'b1;
        idle(2);
        btn_n = 1'b0;
        idle(DEB - 1);
        btn_n = 1'b1;
        idle(IDLE);
        check(1'b0, 1'b0, "R9 split press ignored");

        // R2 exact latency
        @(negedge clk) btn_n = 1'b0;
        idle(DEB + 1);
        check(1'b0, 1'b0, "R2 one edge before accept");
        idle(1);
        check(1'b1, 1'b0, "R2 on at accept edge");
        btn_n = 1'b1;

        // R7: release shorter than the window, press not accepted
        idle(3);
        press(DEB);
        idle(IDLE);
        check(1'b1, 1'b0, "R7 short release blocks press");

        // R10 / R6: bus arrives on the accept edge
        @(negedge clk) btn_n = 1'b0;
        idle(DEB + 1);
        vbus_ok = 1'b1;
        idle(1);
        check(1'b1, 1'b0, "R10 bus beats press");
        btn_n = 1'b1;
        vbus_ok = 1'b0;
        idle(IDLE);
        check(1'b1, 1'b0, "R6 on after bus drops");

        // R10 / R4: ack arrives on the accept edge
        @(negedge clk) btn_n = 1'b0;
        idle(DEB + 1);
        ack_drv = 1'b1;
        idle(1);
        check(1'b0, 1'b0, "R10 ack beats press");
        ack_drv = 1'b0;
        btn_n = 1'b1;
        idle(IDLE);

        // R5: acknowledge looped back to the request
        press(DEB);
        idle(IDLE);
        check(1'b1, 1'b0, "R5 setup on");
        tie_mode = 1'b1;
        begin
            int hi_cnt;
            hi_cnt = 0;
            @(negedge clk) btn_n = 1'b0;
            for (int k = 0; k < DEB + 6; k++) begin
                @(negedge clk);
                if (off_req) hi_cnt++;
            end
            btn_n = 1'b1;
            n_run++;
            if (hi_cnt != 1) begin
                n_fail++;
                $display("FAIL R5 request width: %0d cycles, expected 1", hi_cnt);
            end
        end
        check(1'b0, 1'b0, "R5 off after looped ack");
        tie_mode = 1'b0;
        idle(IDLE);

        // R1: reset while on
        press(DEB);
        idle(IDLE);
        check(1'b1, 1'b0, "R1 setup on");
        rst = 1'b1;
        idle(2);
        check(1'b0, 1'b0, "R1 reset while on");
        rst = 1'b0;
        idle(2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule